// File: doc/BRIEF.md
# Eight-Way Set-Associative L1 Data Cache

This block is a 32 KB level-one data cache that sits between a load/store requester and the next cache level. The array has 128 sets of 8 ways, and each line is 32 bytes wide. A request gives the set index, which is taken from the effective address, and the line tag, which is taken from the physical address. The index and the tag arrive as separate fields. The request also gives a doubleword select inside the line, per-byte enables and 64 bits of write data. A load that hits returns its doubleword on the next cycle. A store that hits merges the enabled bytes into the line and marks the line dirty.

On a miss the cache sends the line address to the next level and waits for the whole line to arrive. It then writes that line into the array in a single cycle. The victim way is the lowest-numbered invalid way of the set. When every way is valid, the victim comes from a 7-bit tree pseudo-LRU state kept per set. A dirty victim is copied in one cycle into one of two line-wide eviction buffers, which then drain to the next level independently of refills. One miss is outstanding at a time.

All transfers use valid/ready handshakes. Two rules govern back-pressure. First, a source that raises valid holds it and its payload until the cycle in which ready is also high. Second, `req_ready` depends only on internal state and never on `req_valid`. The response channel and the fill channel have no ready. The requester and the cache must accept those beats in the cycle they appear.

Top module: `l1d_cache`

## Requirements
- R1: After a synchronous reset, every line is invalid, `req_ready` is 1, and `rsp_valid`, `miss_valid` and `evict_valid` are 0.
- R2: A load that hits, accepted at clock edge t, gives `rsp_valid`=1 after edge t for exactly one cycle. `rsp_data` then holds doubleword `req_dword` of the line, where doubleword d occupies line bits [64d+63:64d].
- R3: A store that hits writes only the byte lanes whose `req_bytes` bit is set, with lane k at bits [8k+7:8k] of the doubleword. The line becomes dirty. A store produces no response.
- R4: A miss raises `miss_valid` after the accepting edge, with `miss_line_addr` = {tag, index}. Both stay stable until `miss_ready` is seen. `req_ready` stays 0 from the accepting edge until the fill edge.
- R5: On the single-cycle `fill_valid` beat, the full 256-bit line is written into the victim way. A load miss then responds with doubleword `req_dword` of the fill data, in the cycle after the fill. A store miss merges its bytes into the filled line and leaves it dirty. A load miss leaves it clean.
- R6: When the set has an invalid way, the fill goes to the lowest-numbered invalid way.
- R7: When all ways are valid, the victim follows the tree. Node 0 picks the upper half when it is 1. The level-2 node 1+v2 picks the upper quarter. The leaf 3+2*v2+v1 picks the odd way. Each hit or fill sets the three nodes on the accessed way's path so that they point away from it.
- R8: A dirty victim is copied to an eviction buffer at the miss-accepting edge. It is presented on `evict_valid`/`evict_line_addr`/`evict_data` in first-in order, and held stable until `evict_ready`. A clean victim produces no eviction.
- R9: With both eviction buffers occupied, `req_ready` is 0, including for requests that would hit. It rises after an eviction handshake frees a buffer.
- R10: At most one valid way of a set matches a given tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid is high |
| req_write | input | 1 | 1 for store, 0 for load |
| req_index | input | 7 | Set index from effective-address bits |
| req_tag | input | 20 | Line tag from physical-address bits |
| req_dword | input | 2 | Doubleword within the line |
| req_bytes | input | 8 | Byte-lane enables for stores |
| req_wdata | input | 64 | Store data |
| rsp_valid | output | 1 | Load data valid, one-cycle pulse |
| rsp_data | output | 64 | Load data |
| miss_valid | output | 1 | Line request to next level |
| miss_ready | input | 1 | Next level took the line request |
| miss_line_addr | output | 27 | {tag, index} of the requested line |
| fill_valid | input | 1 | Refill line present, one-cycle beat |
| fill_data | input | 256 | Refill line |
| evict_valid | output | 1 | Dirty line waiting in an eviction buffer |
| evict_ready | input | 1 | Next level took the eviction |
| evict_line_addr | output | 27 | {tag, index} of the evicted line |
| evict_data | output | 256 | Evicted line contents |

## Verification
The assertions check the handshake properties on every cycle. A pending line request and a pending eviction must hold still until they are taken. A load hit must be answered on the next cycle. The eviction buffers must never be pushed when full or popped when empty. No two valid ways of a set may match the same tag. Other behaviours can be shown only by the bench's scenarios, run against a behavioural model of the whole cache: the invalid-first and tree replacement order, the byte-lane merge for each store width, the clean or dirty state that a fill leaves behind, and the stall when both eviction buffers are full.

// File: rtl/l1d_pkg.sv
package l1d_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ASK  = 2'd1,
    ST_WAIT = 2'd2
  } l1d_state_e;
endpackage

// File: rtl/l1d_tag_match.sv
module l1d_tag_match #(
  parameter int WAYS  = 8,
  parameter int TAG_W = 20,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS*TAG_W-1:0] set_tags_i,
  input  logic [WAYS-1:0]       set_valid_i,
  input  logic [TAG_W-1:0]      tag_i,
  output logic [WAYS-1:0]       hit_vec_o,
  output logic                  hit_o,
  output logic [WAY_W-1:0]      hit_way_o
);
  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    assign hit_vec_o[g] = set_valid_i[g] && (set_tags_i[g*TAG_W +: TAG_W] == tag_i);
  end

  assign hit_o = |hit_vec_o;

  always_comb begin
    hit_way_o = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (hit_vec_o[i]) hit_way_o = WAY_W'(i);
    end
  end
endmodule

// File: rtl/l1d_plru.sv
module l1d_plru #(
  parameter int WAYS = 8,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-2:0]  tree_i,
  input  logic [WAYS-1:0]  valid_i,
  input  logic [WAY_W-1:0] touch_way_i,
  output logic [WAY_W-1:0] victim_o,
  output logic [WAYS-2:0]  tree_next_o
);
  logic [WAY_W-1:0] walk_way;
  logic [WAY_W-1:0] free_way;
  logic             any_free;

  // Follow the tree bits from the root down to a leaf.
  always_comb begin
    logic [WAY_W-1:0] node;
    node     = '0;
    walk_way = '0;
    for (int l = 0; l < WAY_W; l++) begin
      walk_way[WAY_W-1-l] = tree_i[node];
      node = (node << 1) + WAY_W'(1) + WAY_W'(tree_i[node]);
    end
  end

  // The lowest-numbered invalid way wins over the tree.
  always_comb begin
    any_free = 1'b0;
    free_way = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (!valid_i[i]) begin
        any_free = 1'b1;
        free_way = WAY_W'(i);
      end
    end
  end

  assign victim_o = any_free ? free_way : walk_way;

  // Every node on the touched way's path is set to point away from it.
  always_comb begin
    logic [WAY_W-1:0] node;
    logic             b;
    tree_next_o = tree_i;
    node        = '0;
    for (int l = 0; l < WAY_W; l++) begin
      b                 = touch_way_i[WAY_W-1-l];
      tree_next_o[node] = ~b;
      node = (node << 1) + WAY_W'(1) + WAY_W'(b);
    end
  end
endmodule

// File: rtl/l1d_evict_buf.sv
module l1d_evict_buf #(
  parameter int DEPTH  = 2,
  parameter int ADDR_W = 27,
  parameter int LINE_W = 256,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_i,
  input  logic [ADDR_W-1:0] push_addr_i,
  input  logic [LINE_W-1:0] push_line_i,
  input  logic              pop_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [LINE_W-1:0] line_o,
  output logic              full_o
);
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [LINE_W-1:0] line_q [DEPTH];
  logic [PTR_W-1:0]  rd_ptr_q, wr_ptr_q;
  logic [CNT_W-1:0]  count_q;

  assign valid_o = (count_q != '0);
  assign full_o  = (count_q == CNT_W'(DEPTH));
  assign addr_o  = addr_q[rd_ptr_q];
  assign line_o  = line_q[rd_ptr_q];

  always_ff @(posedge clk) begin
    if (push_i) begin
      addr_q[wr_ptr_q] <= push_addr_i;
      line_q[wr_ptr_q] <= push_line_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (push_i) wr_ptr_q <= (wr_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr_q + PTR_W'(1);
      if (pop_i)  rd_ptr_q <= (rd_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr_q + PTR_W'(1);
      count_q <= count_q + CNT_W'(push_i) - CNT_W'(pop_i);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) push_i |-> !full_o); // R9
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst) pop_i |-> valid_o); // R8
endmodule

// File: rtl/l1d_cache.sv
module l1d_cache #(
  parameter int SETS       = 128,
  parameter int WAYS       = 8,
  parameter int LINE_BYTES = 32,
  parameter int WORD_BYTES = 8,
  parameter int TAG_W      = 20,
  parameter int EV_DEPTH   = 2,
  localparam int IDX_W   = $clog2(SETS),
  localparam int WAY_W   = $clog2(WAYS),
  localparam int WORD_W  = WORD_BYTES * 8,
  localparam int LINE_W  = LINE_BYTES * 8,
  localparam int DW_W    = $clog2(LINE_BYTES / WORD_BYTES),
  localparam int LADDR_W = TAG_W + IDX_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [IDX_W-1:0]   req_index,
  input  logic [TAG_W-1:0]   req_tag,
  input  logic [DW_W-1:0]    req_dword,
  input  logic [WORD_BYTES-1:0] req_bytes,
  input  logic [WORD_W-1:0]  req_wdata,
  output logic               rsp_valid,
  output logic [WORD_W-1:0]  rsp_data,
  output logic               miss_valid,
  input  logic               miss_ready,
  output logic [LADDR_W-1:0] miss_line_addr,
  input  logic               fill_valid,
  input  logic [LINE_W-1:0]  fill_data,
  output logic               evict_valid,
  input  logic               evict_ready,
  output logic [LADDR_W-1:0] evict_line_addr,
  output logic [LINE_W-1:0]  evict_data
);
  import l1d_pkg::*;

  // Storage
  logic [LINE_W-1:0] data_q  [SETS*WAYS];
  logic [TAG_W-1:0]  tag_q   [SETS*WAYS];
  logic [WAYS-1:0]   valid_q [SETS];
  logic [WAYS-1:0]   dirty_q [SETS];
  logic [WAYS-2:0]   plru_q  [SETS];

  l1d_state_e state_q;

  // Parked miss
  logic [IDX_W-1:0]      pend_index;
  logic [TAG_W-1:0]      pend_tag;
  logic [DW_W-1:0]       pend_dword;
  logic [WORD_BYTES-1:0] pend_bytes;
  logic [WORD_W-1:0]     pend_wdata;
  logic                  pend_write;
  logic [WAY_W-1:0]      pend_way;

  logic              rsp_valid_q;
  logic [WORD_W-1:0] rsp_data_q;

  function automatic logic [LINE_W-1:0] put_bytes(
    input logic [LINE_W-1:0]     line,
    input logic [DW_W-1:0]       dw,
    input logic [WORD_BYTES-1:0] be,
    input logic [WORD_W-1:0]     wd
  );
    logic [LINE_W-1:0] r;
    r = line;
    for (int b = 0; b < WORD_BYTES; b++) begin
      if (be[b]) r[int'(dw)*WORD_W + b*8 +: 8] = wd[b*8 +: 8];
    end
    return r;
  endfunction

  function automatic logic [WORD_W-1:0] get_word(
    input logic [LINE_W-1:0] line,
    input logic [DW_W-1:0]   dw
  );
    return line[int'(dw)*WORD_W +: WORD_W];
  endfunction

  // Lookup
  logic [WAYS*TAG_W-1:0] set_tags;
  logic [WAYS-1:0]       hit_vec;
  logic                  hit;
  logic [WAY_W-1:0]      hit_way;

  for (genvar g = 0; g < WAYS; g++) begin : g_tags
    assign set_tags[g*TAG_W +: TAG_W] = tag_q[{req_index, WAY_W'(g)}];
  end

  l1d_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
    .set_tags_i  (set_tags),
    .set_valid_i (valid_q[req_index]),
    .tag_i       (req_tag),
    .hit_vec_o   (hit_vec),
    .hit_o       (hit),
    .hit_way_o   (hit_way)
  );

  // Replacement
  logic [IDX_W-1:0] lk_set;
  logic [WAY_W-1:0] touch_way;
  logic [WAY_W-1:0] victim;
  logic [WAYS-2:0]  tree_next;

  assign lk_set    = (state_q == ST_WAIT) ? pend_index : req_index;
  assign touch_way = (state_q == ST_WAIT) ? pend_way : hit_way;

  l1d_plru #(.WAYS(WAYS)) u_plru (
    .tree_i      (plru_q[lk_set]),
    .valid_i     (valid_q[lk_set]),
    .touch_way_i (touch_way),
    .victim_o    (victim),
    .tree_next_o (tree_next)
  );

  // Handshake decode
  logic accept, fill_now, ev_full, ev_push, ev_pop, vict_dirty;
  logic [LINE_W-1:0] hit_line, vict_line;

  assign accept     = req_valid && req_ready;
  assign fill_now   = (state_q == ST_WAIT) && fill_valid;
  assign hit_line   = data_q[{req_index, hit_way}];
  assign vict_line  = data_q[{req_index, victim}];
  assign vict_dirty = valid_q[req_index][victim] && dirty_q[req_index][victim];
  assign ev_push    = accept && !hit && vict_dirty;
  assign ev_pop     = evict_valid && evict_ready;

  l1d_evict_buf #(.DEPTH(EV_DEPTH), .ADDR_W(LADDR_W), .LINE_W(LINE_W)) u_evict (
    .clk         (clk),
    .rst         (rst),
    .push_i      (ev_push),
    .push_addr_i ({tag_q[{req_index, victim}], req_index}),
    .push_line_i (vict_line),
    .pop_i       (ev_pop),
    .valid_o     (evict_valid),
    .addr_o      (evict_line_addr),
    .line_o      (evict_data),
    .full_o      (ev_full)
  );

  assign req_ready      = (state_q == ST_IDLE) && !ev_full;
  assign miss_valid     = (state_q == ST_ASK);
  assign miss_line_addr = {pend_tag, pend_index};
  assign rsp_valid      = rsp_valid_q;
  assign rsp_data       = rsp_data_q;

  // Single line write port: store hit or refill
  logic                    wr_en;
  logic [IDX_W+WAY_W-1:0]  wr_slot;
  logic [LINE_W-1:0]       wr_line;

  always_comb begin
    wr_en   = 1'b0;
    wr_slot = {req_index, hit_way};
    wr_line = hit_line;
    if (fill_now) begin
      wr_en   = 1'b1;
      wr_slot = {pend_index, pend_way};
      wr_line = pend_write ? put_bytes(fill_data, pend_dword, pend_bytes, pend_wdata) : fill_data;
    end else if (accept && hit && req_write) begin
      wr_en   = 1'b1;
      wr_line = put_bytes(hit_line, req_dword, req_bytes, req_wdata);
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) data_q[wr_slot] <= wr_line;
    if (fill_now) tag_q[{pend_index, pend_way}] <= pend_tag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
      pend_index  <= '0;
      pend_tag    <= '0;
      pend_dword  <= '0;
      pend_bytes  <= '0;
      pend_wdata  <= '0;
      pend_write  <= 1'b0;
      pend_way    <= '0;
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
        plru_q[s]  <= '0;
      end
    end else begin
      rsp_valid_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            if (hit) begin
              plru_q[req_index] <= tree_next;
              if (req_write) begin
                dirty_q[req_index][hit_way] <= 1'b1;
              end else begin
                rsp_valid_q <= 1'b1;
                rsp_data_q  <= get_word(hit_line, req_dword);
              end
            end else begin
              pend_index <= req_index;
              pend_tag   <= req_tag;
              pend_dword <= req_dword;
              pend_bytes <= req_bytes;
              pend_wdata <= req_wdata;
              pend_write <= req_write;
              pend_way   <= victim;
              valid_q[req_index][victim] <= 1'b0;
              dirty_q[req_index][victim] <= 1'b0;
              state_q    <= ST_ASK;
            end
          end
        end
        ST_ASK: begin
          if (miss_ready) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (fill_valid) begin
            valid_q[pend_index][pend_way] <= 1'b1;
            dirty_q[pend_index][pend_way] <= pend_write;
            plru_q[pend_index]            <= tree_next;
            if (!pend_write) begin
              rsp_valid_q <= 1'b1;
              rsp_data_q  <= get_word(fill_data, pend_dword);
            end
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_ONE_HIT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && state_q == ST_IDLE) |-> $onehot0(hit_vec)); // R10
  AST_LOAD_HIT_RSP: assert property (@(posedge clk) disable iff (rst)
    (accept && hit && !req_write) |=> rsp_valid); // R2
  AST_MISS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (miss_valid && !miss_ready) |=> (miss_valid && $stable(miss_line_addr))); // R4
  AST_MISS_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    miss_valid |-> !req_ready); // R4
  AST_EVICT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (evict_valid && !evict_ready) |=> (evict_valid && $stable(evict_line_addr) && $stable(evict_data))); // R8
endmodule

// File: tb/l1d_cache_bench.sv
module l1d_cache_bench;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic         req_write = 1'b0;
  logic [6:0]   req_index = '0;
  logic [19:0]  req_tag = '0;
  logic [1:0]   req_dword = '0;
  logic [7:0]   req_bytes = '0;
  logic [63:0]  req_wdata = '0;
  logic         rsp_valid;
  logic [63:0]  rsp_data;
  logic         miss_valid;
  logic         miss_ready = 1'b0;
  logic [26:0]  miss_line_addr;
  logic         fill_valid = 1'b0;
  logic [255:0] fill_data = '0;
  logic         evict_valid;
  logic         evict_ready = 1'b0;
  logic [26:0]  evict_line_addr;
  logic [255:0] evict_data;

  always #5 clk = ~clk;

  l1d_cache u_l1d_cache (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_index(req_index), .req_tag(req_tag), .req_dword(req_dword),
    .req_bytes(req_bytes), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .miss_valid(miss_valid), .miss_ready(miss_ready), .miss_line_addr(miss_line_addr),
    .fill_valid(fill_valid), .fill_data(fill_data),
    .evict_valid(evict_valid), .evict_ready(evict_ready),
    .evict_line_addr(evict_line_addr), .evict_data(evict_data)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit running = 1'b0;
  bit ev_gate = 1'b1;

  task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [255:0] m_data  [128][8];
  logic [19:0]  m_tag   [128][8];
  bit           m_val   [128][8];
  bit           m_dirty [128][8];
  bit [6:0]     m_tree  [128];
  int           m_busy;
  int           p_idx, p_dw, p_way;
  logic [19:0]  p_tag;
  logic [7:0]   p_be;
  logic [63:0]  p_wd;
  bit           p_wr;
  logic [26:0]  q_addr [$];
  logic [255:0] q_line [$];
  bit           e_rsp_valid;
  logic [63:0]  e_rsp_data;

  function automatic int pick_way(input int s);
    int t2, t1, t0;
    for (int w = 0; w < 8; w++) if (!m_val[s][w]) return w;
    t2 = m_tree[s][0];
    t1 = m_tree[s][1 + t2];
    t0 = m_tree[s][3 + 2*t2 + t1];
    return 4*t2 + 2*t1 + t0;
  endfunction

  function automatic void touch(input int s, input int w);
    m_tree[s][0]         = !(w >= 4);
    m_tree[s][1 + w/4]   = !((w/2) % 2);
    m_tree[s][3 + w/2]   = !(w % 2);
  endfunction

  function automatic logic [255:0] merge(input logic [255:0] l, input int dw,
                                         input logic [7:0] be, input logic [63:0] wd);
    logic [255:0] r = l;
    for (int k = 0; k < 8; k++) if (be[k]) r[dw*64 + k*8 +: 8] = wd[k*8 +: 8];
    return r;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < 128; s++) begin
        m_tree[s] = '0;
        for (int w = 0; w < 8; w++) begin m_val[s][w] = 0; m_dirty[s][w] = 0; end
      end
      m_busy = 0;
      q_addr.delete();
      q_line.delete();
      e_rsp_valid = 0;
      e_rsp_data = '0;
    end else begin
      bit rdy_now;
      rdy_now = (m_busy == 0) && (q_addr.size() < 2);
      e_rsp_valid = 0;
      if (q_addr.size() > 0 && evict_ready) begin
        void'(q_addr.pop_front());
        void'(q_line.pop_front());
      end
      if (m_busy == 1) begin
        if (miss_ready) m_busy = 2;
      end else if (m_busy == 2) begin
        if (fill_valid) begin
          m_data[p_idx][p_way]  = p_wr ? merge(fill_data, p_dw, p_be, p_wd) : fill_data;
          m_tag[p_idx][p_way]   = p_tag;
          m_val[p_idx][p_way]   = 1;
          m_dirty[p_idx][p_way] = p_wr;
          touch(p_idx, p_way);
          if (!p_wr) begin e_rsp_valid = 1; e_rsp_data = fill_data[p_dw*64 +: 64]; end
          m_busy = 0;
        end
      end else if (req_valid && rdy_now) begin
        int s, hw;
        s = int'(req_index);
        hw = -1;
        for (int w = 0; w < 8; w++) if (m_val[s][w] && m_tag[s][w] == req_tag) hw = w;
        if (hw >= 0) begin
          touch(s, hw);
          if (req_write) begin
            m_data[s][hw] = merge(m_data[s][hw], int'(req_dword), req_bytes, req_wdata);
            m_dirty[s][hw] = 1;
          end else begin
            e_rsp_valid = 1;
            e_rsp_data = m_data[s][hw][int'(req_dword)*64 +: 64];
          end
        end else begin
          int v;
          v = pick_way(s);
          if (m_val[s][v] && m_dirty[s][v]) begin
            q_addr.push_back({m_tag[s][v], req_index});
            q_line.push_back(m_data[s][v]);
          end
          m_val[s][v] = 0;
          m_dirty[s][v] = 0;
          p_idx = s; p_way = v; p_tag = req_tag; p_dw = int'(req_dword);
          p_be = req_bytes; p_wd = req_wdata; p_wr = req_write;
          m_busy = 1;
        end
      end
    end
  end

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (running) begin
      chk("R4/R9 req_ready", 256'(req_ready), 256'((m_busy == 0) && (q_addr.size() < 2)));
      chk("R2 rsp_valid", 256'(rsp_valid), 256'(e_rsp_valid));
      if (e_rsp_valid) chk("R2/R3/R5 rsp_data", 256'(rsp_data), 256'(e_rsp_data));
      chk("R4 miss_valid", 256'(miss_valid), 256'(m_busy == 1));
      if (m_busy == 1) chk("R4 miss_line_addr", 256'(miss_line_addr), 256'({p_tag, 7'(p_idx)}));
      chk("R8 evict_valid", 256'(evict_valid), 256'(q_addr.size() > 0));
      if (q_addr.size() > 0) begin
        chk("R6/R7/R8 evict_line_addr", 256'(evict_line_addr), 256'(q_addr[0]));
        chk("R8 evict_data", evict_data, q_line[0]);
      end
    end
  end

  // ---------------- next-level responders ----------------
  function automatic logic [255:0] pat(input logic [26:0] a);
    logic [255:0] r;
    for (int d = 0; d < 4; d++) r[d*64 +: 64] = {16'hA5C3, 8'(d), 13'h0, a};
    return r;
  endfunction

  initial begin
    int dly = 0;
    logic [26:0] a;
    forever begin
      @(negedge clk);
      if (miss_valid && !rst) begin
        dly = (dly + 1) % 3;
        repeat (dly) @(negedge clk);
        miss_ready = 1'b1;
        a = miss_line_addr;
        @(negedge clk);
        miss_ready = 1'b0;
        repeat (2 - dly) @(negedge clk);
        fill_valid = 1'b1;
        fill_data = pat(a);
        @(negedge clk);
        fill_valid = 1'b0;
      end
    end
  end

  initial begin
    logic [7:0] lf = 8'h5B;
    forever begin
      @(negedge clk);
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      evict_ready = ev_gate && lf[2];
    end
  end

  // ---------------- requester ----------------
  task automatic issue(input bit wr, input int idx, input logic [19:0] tag,
                       input int dw, input logic [7:0] be, input logic [63:0] wd);
    req_valid = 1'b1;
    req_write = wr;
    req_index = 7'(idx);
    req_tag   = tag;
    req_dword = 2'(dw);
    req_bytes = be;
    req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic settle();
    while (!req_ready || miss_valid) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R4 watchdog act=hung exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] r = 16'hACE1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1 req_ready", 256'(req_ready), 256'(1));
    chk("R1 rsp_valid", 256'(rsp_valid), 256'(0));
    chk("R1 miss_valid", 256'(miss_valid), 256'(0));
    chk("R1 evict_valid", 256'(evict_valid), 256'(0));
    running = 1'b1;

    // R4/R5: load miss then R2 load hits on other doublewords
    issue(0, 5, 20'h0ABCD, 2, 8'h00, '0);
    issue(0, 5, 20'h0ABCD, 0, 8'h00, '0);
    issue(0, 5, 20'h0ABCD, 3, 8'h00, '0);

    // R3: byte, halfword, word and doubleword stores, each read back
    issue(1, 5, 20'h0ABCD, 1, 8'h04, 64'h0000_0000_00EE_0000);
    issue(0, 5, 20'h0ABCD, 1, 8'h00, '0);
    issue(1, 5, 20'h0ABCD, 1, 8'h30, 64'h0000_1234_0000_0000);
    issue(0, 5, 20'h0ABCD, 1, 8'h00, '0);
    issue(1, 5, 20'h0ABCD, 3, 8'hF0, 64'hDEAD_BEEF_0000_0000);
    issue(0, 5, 20'h0ABCD, 3, 8'h00, '0);
    issue(1, 5, 20'h0ABCD, 0, 8'hFF, 64'h0123_4567_89AB_CDEF);
    issue(0, 5, 20'h0ABCD, 0, 8'h00, '0);

    // R6: set 9 fills its ways lowest-first with dirty lines via store misses
    for (int t = 0; t < 8; t++) issue(1, 9, 20'h00100 + 20'(t), 0, 8'hFF, 64'(t) * 64'h1111);
    // R10: re-hit two of them, moving the tree
    issue(0, 9, 20'h00102, 0, 8'h00, '0);
    issue(0, 9, 20'h00105, 0, 8'h00, '0);

    // R7/R8/R9: two dirty PLRU victims fill both eviction buffers while drain is blocked
    ev_gate = 1'b0;
    issue(1, 9, 20'h00108, 1, 8'h0F, 64'h55);
    issue(1, 9, 20'h00109, 2, 8'hF0, 64'hAA00_0000_0000);
    while (miss_valid || !fill_valid) @(negedge clk);
    repeat (6) @(negedge clk);
    chk("R9 req_ready with both buffers full", 256'(req_ready), 256'(0));
    ev_gate = 1'b1;
    settle();

    // Mixed traffic: hits, clean and dirty evictions, all store widths
    for (int n = 0; n < 400; n++) begin
      int sz, nb, off, idx;
      logic [7:0] be;
      r = {r[14:0], r[15] ^ r[13] ^ r[12] ^ r[10]};
      ev_gate = r[9] | r[4];
      sz  = int'(r[3:2]);
      nb  = 1 << sz;
      off = (int'(r[15:12]) % (8 / nb)) * nb;
      be  = 8'(((1 << nb) - 1) << off);
      case (r[11:10])
        2'd0: idx = 3;
        2'd1: idx = 9;
        2'd2: idx = 5;
        default: idx = 77;
      endcase
      issue(r[0], idx, 20'h00100 + 20'(int'(r[8:5]) % 11), int'(r[1:0] ^ r[7:6]), be,
            {r, ~r, r ^ 16'h3C3C, 16'(n)});
    end
    ev_gate = 1'b1;
    settle();
    while (evict_valid) @(negedge clk);
    repeat (4) @(negedge clk);
    running = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule